// File: doc/BRIEF.md
# Power-On Strap Latch and Frequency-Code Select

This block sits between a small group of dual-purpose pads and the frequency synthesizer of a clock generator. While power-on reset is asserted, the pads act as inputs and carry board-level strap levels. The block freezes those levels right after reset is released, holds the pads in input mode for a short settling window, and then lets the pad drivers turn on so the same pins can carry clocks.

After reset, a source bit in the configuration byte chooses the frequency code passed to the synthesizer. One setting uses the frozen strap code and the other uses a code written by software. The block also decodes two special codes: one puts the main outputs into high impedance and the other selects a divided-crystal test mode. It forms the spread-enable result from three separate configuration bits. A readback byte returns the configuration byte with its strap-backed low bits replaced by the captured strap levels.

Top module: `strap_sel_top`

## Requirements
- R1: While `rstN` is low, `padOe` is 0, the captured strap code is 0 (so `cfgReadBack[2:0]` is 0), and with source bit 0 `activeCode` is 0.
- R2: `padOe` stays 0 at the first rising clock edge after `rstN` goes high, becomes 1 at the second edge, and then stays 1 until the next reset.
- R3: The strap code is captured from `strapPins` at the first rising clock edge after reset is released. Later changes on `strapPins` do not change `cfgReadBack[2:0]` or the strap-sourced `activeCode`.
- R4: The source bit is `cfgByte[7]`. When it is 0, `activeCode` is the captured 3-bit strap code zero-extended to 4 bits. When it is 1, `activeCode` is `cfgByte[3:0]`.
- R5: `cfgReadBack` equals `cfgByte[7:3]` in bits 7..3 and the captured strap code in bits 2..0.
- R6: `spreadOn` is 1 only when `cfgByte[6]`, `cfgByte[4]` and `srcSpreadEn` are all 1.
- R7: `freqHiZ` is 1 exactly when `activeCode` is 4'b0000. `freqTest` is 1 exactly when `activeCode` is 4'b0001. They are never both 1.
- R8: A new assertion and release of `rstN` clears the captured code and captures the strap levels again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous assert |
| strapPins | input | 3 | Levels seen on the dual-purpose pads |
| cfgByte | input | 8 | Frequency configuration byte from the register file |
| srcSpreadEn | input | 1 | Spread-enable bit from the second configuration byte |
| padOe | output | 1 | Drive enable for the dual-purpose pads |
| activeCode | output | 4 | Frequency code sent to the synthesizer |
| freqHiZ | output | 1 | Active code requests high-impedance outputs |
| freqTest | output | 1 | Active code requests the divided-crystal test mode |
| spreadOn | output | 1 | Spread fully enabled |
| cfgReadBack | output | 8 | Configuration byte with captured straps in bits 2..0 |

## Verification
Strap values are captured after several resets that use random and directed patterns, including all zeros, the high-impedance code and the test code. Changing the pins after capture shows whether the latch is frozen or still transparent. Each captured value is checked with both settings of the source bit, which shows whether the mux selects the right operand. All eight combinations of the three spread bits are checked, so the result is shown to be a three-way AND and not any smaller function. The pad enable is sampled in the cycles around reset release to show the exact two-cycle hold.

// File: rtl/strap_sel_pkg.sv
package strap_sel_pkg;
  typedef struct packed {
    logic capture;
    logic padOe;
  } strapCtl_t;
endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_sel_pkg::*;
#(
  parameter int SETTLE = 2
) (
  input  logic      clk,
  input  logic      rstN,
  output strapCtl_t ctl
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign ctl.capture = (cnt == '0);
  assign ctl.padOe   = (cnt == LAST);

  // R2
  oe_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.padOe |=> ctl.padOe);

  // R2
  oe_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.padOe) |-> $past(rstN));

  // R3
  cap_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> !ctl.capture);
endmodule

// File: rtl/strap_dp.sv
module strap_dp
  import strap_sel_pkg::*;
#(
  parameter int STRAP_W = 3,
  parameter int CODE_W  = 4,
  parameter int REG_W   = 8,
  parameter int SRC_POS = 7,
  parameter int SSA_POS = 6,
  parameter int SSB_POS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  strapCtl_t          ctl,
  input  logic [STRAP_W-1:0] strapPins,
  input  logic [REG_W-1:0]   cfgByte,
  input  logic               srcSpreadEn,
  output logic [CODE_W-1:0]  activeCode,
  output logic               freqHiZ,
  output logic               freqTest,
  output logic               spreadOn,
  output logic [REG_W-1:0]   cfgReadBack
);
  localparam int PAD_W = CODE_W - STRAP_W;

  logic [STRAP_W-1:0] strapQ;
  logic [CODE_W-1:0]  strapCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strapQ <= '0;
    else if (ctl.capture) strapQ <= strapPins;
  end

  assign strapCode   = {{PAD_W{1'b0}}, strapQ};
  assign activeCode  = cfgByte[SRC_POS] ? cfgByte[CODE_W-1:0] : strapCode;
  assign freqHiZ     = (activeCode == CODE_W'(0));
  assign freqTest    = (activeCode == CODE_W'(1));
  assign spreadOn    = cfgByte[SSA_POS] & cfgByte[SSB_POS] & srcSpreadEn;
  assign cfgReadBack = {cfgByte[REG_W-1:STRAP_W], strapQ};

  // R3
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(strapQ));

  // R3
  cap_before_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.padOe |-> !ctl.capture);

  // R7
  code_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({freqHiZ, freqTest}));
endmodule

// File: rtl/strap_sel_top.sv
module strap_sel_top
  import strap_sel_pkg::*;
#(
  parameter int STRAP_W = 3,
  parameter int CODE_W  = 4,
  parameter int REG_W   = 8,
  parameter int SETTLE  = 2,
  parameter int SRC_POS = 7,
  parameter int SSA_POS = 6,
  parameter int SSB_POS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] strapPins,
  input  logic [REG_W-1:0]   cfgByte,
  input  logic               srcSpreadEn,
  output logic               padOe,
  output logic [CODE_W-1:0]  activeCode,
  output logic               freqHiZ,
  output logic               freqTest,
  output logic               spreadOn,
  output logic [REG_W-1:0]   cfgReadBack
);
  strapCtl_t ctl;

  strap_ctrl #(.SETTLE(SETTLE)) ctrl_i (
    .clk (clk),
    .rstN(rstN),
    .ctl (ctl)
  );

  strap_dp #(
    .STRAP_W(STRAP_W), .CODE_W(CODE_W), .REG_W(REG_W),
    .SRC_POS(SRC_POS), .SSA_POS(SSA_POS), .SSB_POS(SSB_POS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .strapPins  (strapPins),
    .cfgByte    (cfgByte),
    .srcSpreadEn(srcSpreadEn),
    .activeCode (activeCode),
    .freqHiZ    (freqHiZ),
    .freqTest   (freqTest),
    .spreadOn   (spreadOn),
    .cfgReadBack(cfgReadBack)
  );

  assign padOe = ctl.padOe;

  // R1
  oe_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    padOe |-> $past(rstN));
endmodule

// File: tb/strap_sel_tb.sv
module strap_sel_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] strapPins = 3'b000;
  logic [7:0] cfgByte = 8'h00;
  logic       srcSpreadEn = 1'b0;
  logic       padOe, freqHiZ, freqTest, spreadOn;
  logic [3:0] activeCode;
  logic [7:0] cfgReadBack;

  int total = 0;
  int bad = 0;
  logic [2:0] heldStrap = 3'b000;

  always #2 clk = ~clk;

  strap_sel_top dut_i (
    .clk(clk), .rstN(rstN), .strapPins(strapPins), .cfgByte(cfgByte),
    .srcSpreadEn(srcSpreadEn), .padOe(padOe), .activeCode(activeCode),
    .freqHiZ(freqHiZ), .freqTest(freqTest), .spreadOn(spreadOn),
    .cfgReadBack(cfgReadBack)
  );

  function automatic logic [3:0] expCode(logic [7:0] cfg, logic [2:0] s);
    return cfg[7] ? cfg[3:0] : {1'b0, s};
  endfunction

  function automatic logic [7:0] expRead(logic [7:0] cfg, logic [2:0] s);
    return {cfg[7:3], s};
  endfunction

  function automatic logic expSpread(logic [7:0] cfg, logic se);
    return cfg[6] & cfg[4] & se;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkOutputs(input string req);
    logic [3:0] c;
    c = expCode(cfgByte, heldStrap);
    chk(activeCode == c, {req, " code"}, activeCode, c);
    chk(cfgReadBack == expRead(cfgByte, heldStrap), {req, " readback"},
        cfgReadBack, expRead(cfgByte, heldStrap));
    chk(spreadOn == expSpread(cfgByte, srcSpreadEn), {req, " spread R6"},
        spreadOn, expSpread(cfgByte, srcSpreadEn));
    chk(freqHiZ == (c == 4'd0), {req, " hiz R7"}, freqHiZ, c == 4'd0);
    chk(freqTest == (c == 4'd1), {req, " test R7"}, freqTest, c == 4'd1);
  endtask

  task automatic doReset(input logic [2:0] s);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(padOe == 1'b0, "R1 oe in reset", padOe, 0);
    chk(cfgReadBack[2:0] == 3'b000, "R1 strap cleared", cfgReadBack[2:0], 0);
    @(negedge clk);
    strapPins = s;
    rstN = 1'b1;
    @(negedge clk);
    heldStrap = s;
    chk(padOe == 1'b0, "R2 oe low after edge 1", padOe, 0);
    chk(cfgReadBack[2:0] == s, "R3 capture", cfgReadBack[2:0], s);
    @(negedge clk);
    chk(padOe == 1'b1, "R2 oe high after edge 2", padOe, 1);
  endtask

  initial begin
    int timer = 0;
    forever begin
      @(posedge clk);
      timer++;
      if (timer > 50000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", timer, 50000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd7731));
    strapPins = 3'b101;
    cfgByte = 8'h00;
    repeat (3) @(negedge clk);
    chk(padOe == 1'b0, "R1 oe at start", padOe, 0);
    chk(activeCode == 4'd0, "R1 code at start", activeCode, 0);
    chk(cfgReadBack == 8'h00, "R1 readback at start", cfgReadBack, 0);

    doReset(3'b110);
    checkOutputs("R4 strap source");
    strapPins = 3'b001;
    repeat (3) @(negedge clk);
    checkOutputs("R3 pins ignored after capture");
    chk(padOe == 1'b1, "R2 oe stays high", padOe, 1);

    cfgByte = 8'h8B;
    @(negedge clk);
    checkOutputs("R4 register source");
    cfgByte = 8'hF8;
    @(negedge clk);
    checkOutputs("R5 readback upper bits");

    for (int i = 0; i < 8; i++) begin
      cfgByte = {1'b0, i[2], 1'b0, i[1], 4'h5};
      srcSpreadEn = i[0];
      @(negedge clk);
      chk(spreadOn == (i == 7), "R6 spread combo", spreadOn, i == 7);
    end

    doReset(3'b000);
    cfgByte = 8'h00;
    @(negedge clk);
    checkOutputs("R7 strap hiz code");
    chk(freqHiZ == 1'b1, "R7 hiz set", freqHiZ, 1);
    doReset(3'b001);
    checkOutputs("R8 recapture test code");
    chk(freqTest == 1'b1, "R7 test set", freqTest, 1);
    cfgByte = 8'h80;
    @(negedge clk);
    chk(freqHiZ == 1'b1, "R7 register hiz", freqHiZ, 1);
    cfgByte = 8'h81;
    @(negedge clk);
    chk(freqTest == 1'b1, "R7 register test", freqTest, 1);

    for (int r = 0; r < 12; r++) begin
      doReset(3'($urandom));
      for (int k = 0; k < 6; k++) begin
        cfgByte = 8'($urandom);
        srcSpreadEn = 1'($urandom);
        strapPins = 3'($urandom);
        @(negedge clk);
        checkOutputs("R8 random");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule